// File: doc/BRIEF.md
# Wrapping Hardware Stack Pointer

This unit owns the stack pointer of a small 8-bit processor whose stack lives in a 64-byte window at the top of a 256-byte zero page. Only the six low bits of the pointer are real state. The upper ten bits are fixed by hardware, so the full 16-bit value always falls between 0x00C0 and 0x00FF. The pointer always names the next free byte. A push stores at that byte and then moves down. A pop first moves up and then reads. Both directions wrap silently inside the window and raise no flag.

The instruction decoder gives the unit one command per instruction. The unit then drives the memory strobes, the byte address and a data-select code, one byte per clock. The data-select code tells the datapath which register to place on the bus, or which register to load. The commands are:

- single-byte push and pop;
- a two-byte subroutine frame and its return;
- a five-byte interrupt frame and its return;
- a stack reset;
- a direct load of the writable pointer bits.

While a frame is in progress the unit reports busy, and it ignores any new command.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is asserted and after it is released, `sp` reads 0x00FF, and `busy`, `mem_we` and `mem_re` are 0.
- R2: `sp` bits 15:8 always read 0 and bits 7:6 always read 1. Only bits 5:0 change.
- R3: A push (op code 1) gives one busy cycle. In that cycle `mem_we`=1, `mem_addr` equals `sp`, and `data_sel` is 0 (operand). After the cycle, `sp` bits 5:0 have gone down by one.
- R4: A pop (op code 2) gives one busy cycle. In that cycle `mem_re`=1, `mem_addr` equals `sp` with bits 5:0 raised by one, and `data_sel`=0. After the cycle, `sp` equals that address.
- R5: Going down from 0x00C0 gives 0x00FF, and going up from 0x00FF gives 0x00C0. No flag is raised in either case.
- R6: A call frame (op code 3) writes 2 bytes in 2 cycles: PCL (sel 1) and then PCH (sel 2), at descending addresses. A return (op code 4) reads PCH and then PCL at ascending addresses.
- R7: An interrupt frame (op code 5) writes 5 bytes in 5 cycles, in the order PCL, PCH, X, A, CC (sel 1, 2, 3, 4, 5). The first byte goes to the current `sp`. No select code names the Y register.
- R8: An interrupt return (op code 6) reads 5 bytes in the order CC, A, X, PCH, PCL (sel 5, 4, 3, 2, 1), at ascending addresses.
- R9: A reset-stack command (op code 7) issued while idle sets `sp` to 0x00FF at the next clock. It causes no memory access.
- R10: A low-byte load (op code 8) issued while idle copies `sp_load_val` into bits 5:0 at the next clock. Bits 7:6 stay 1, and there is no memory access.
- R11: Any command presented while `busy` is 1 has no effect. The current frame continues with unchanged addresses and select codes.
- R12: One memory access, a read or a write, takes place in every busy cycle and in no other cycle. `mem_we` and `mem_re` are never both 1. When idle, with op code 0, `sp` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Command: 0 none, 1 push, 2 pop, 3 call, 4 return, 5 interrupt, 6 interrupt return, 7 reset stack, 8 load low bits |
| sp_load_val | input | 6 | Value for the writable pointer bits, used by op 8 |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | A frame is in progress; commands are ignored |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 16 | Stack byte address for the current access |
| data_sel | output | 3 | Register for this byte: 0 operand, 1 PCL, 2 PCH, 3 X, 4 A, 5 CC |

## Verification
The hardest case to reach from the ports is a multi-byte frame that crosses the window boundary while new commands are being driven at it. The bench reaches it in two ways. Directed steps load the pointer next to either boundary before an interrupt frame or its return. Random commands are also driven onto `op` during every busy cycle. The bench tracks its own pointer model, so every address and select code is checked in every cycle of a frame, including frames that wrap in the middle.

// File: rtl/spu_pkg.sv
package spu_pkg;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_PUSH     = 4'd1,
        OP_POP      = 4'd2,
        OP_CALL     = 4'd3,
        OP_RET      = 4'd4,
        OP_INTR     = 4'd5,
        OP_IRET     = 4'd6,
        OP_RESET_SP = 4'd7,
        OP_LOAD_LO  = 4'd8
    } spu_op_e;

    typedef enum logic [1:0] {
        FR_ONE  = 2'd0,
        FR_CALL = 2'd1,
        FR_INTR = 2'd2
    } frame_e;

    typedef enum logic [2:0] {
        SEL_OPND = 3'd0,
        SEL_PCL  = 3'd1,
        SEL_PCH  = 3'd2,
        SEL_X    = 3'd3,
        SEL_A    = 3'd4,
        SEL_CC   = 3'd5
    } sel_e;

    localparam int MAX_FRAME = 5;
    localparam int IDX_W     = $clog2(MAX_FRAME);

    // Index of the final byte of each frame kind.
    function automatic logic [IDX_W-1:0] frame_last_idx(frame_e kind);
        case (kind)
            FR_CALL: frame_last_idx = IDX_W'(1);
            FR_INTR: frame_last_idx = IDX_W'(MAX_FRAME - 1);
            default: frame_last_idx = '0;
        endcase
    endfunction

endpackage

// File: rtl/spu_window_math.sv
module spu_window_math #(
    parameter int SP_W   = 16,
    parameter int PAGE_W = 8,
    parameter int WIN_W  = 6
) (
    input  logic [WIN_W-1:0] win,
    output logic [WIN_W-1:0] win_inc,
    output logic [WIN_W-1:0] win_dec,
    output logic [SP_W-1:0]  addr_cur,
    output logic [SP_W-1:0]  addr_inc
);
    localparam int FORCE_W = PAGE_W - WIN_W;
    localparam int ZERO_W  = SP_W - PAGE_W;

    function automatic logic [SP_W-1:0] compose(logic [WIN_W-1:0] w);
        compose = {{ZERO_W{1'b0}}, {FORCE_W{1'b1}}, w};
    endfunction

    // Modulo arithmetic on the window bits gives the silent wrap.
    always_comb begin
        win_inc  = win + WIN_W'(1);
        win_dec  = win - WIN_W'(1);
        addr_cur = compose(win);
        addr_inc = compose(win_inc);
    end
endmodule

// File: rtl/spu_frame_order.sv
module spu_frame_order
    import spu_pkg::*;
(
    input  frame_e           kind,
    input  logic             is_pop,
    input  logic [IDX_W-1:0] idx,
    output sel_e             sel,
    output logic             last
);
    logic [IDX_W-1:0] span;
    logic [IDX_W-1:0] pos;

    // A pop walks the push order backwards.
    always_comb begin
        span = frame_last_idx(kind);
        last = (idx == span);
        pos  = is_pop ? (span - idx) : idx;
        sel  = SEL_OPND;
        case (kind)
            FR_CALL: sel = (pos == '0) ? SEL_PCL : SEL_PCH;
            FR_INTR: begin
                case (pos)
                    IDX_W'(0): sel = SEL_PCL;
                    IDX_W'(1): sel = SEL_PCH;
                    IDX_W'(2): sel = SEL_X;
                    IDX_W'(3): sel = SEL_A;
                    default:   sel = SEL_CC;
                endcase
            end
            default: sel = SEL_OPND;
        endcase
    end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import spu_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int PAGE_W = 8,
    parameter int WIN_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op,
    input  logic [WIN_W-1:0] sp_load_val,
    output logic [SP_W-1:0]  sp,
    output logic             busy,
    output logic             mem_we,
    output logic             mem_re,
    output logic [SP_W-1:0]  mem_addr,
    output logic [2:0]       data_sel
);
    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             active;
        logic             is_pop;
        frame_e           kind;
        logic [IDX_W-1:0] idx;
    } state_t;

    state_t s_d, s_q;

    logic [WIN_W-1:0] win_inc, win_dec;
    logic [SP_W-1:0]  addr_cur, addr_inc;
    sel_e             step_sel;
    logic             step_last;
    spu_op_e          op_e;

    spu_window_math #(.SP_W(SP_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_math (
        .win      (s_q.win),
        .win_inc  (win_inc),
        .win_dec  (win_dec),
        .addr_cur (addr_cur),
        .addr_inc (addr_inc)
    );

    spu_frame_order u_order (
        .kind   (s_q.kind),
        .is_pop (s_q.is_pop),
        .idx    (s_q.idx),
        .sel    (step_sel),
        .last   (step_last)
    );

    assign op_e = spu_op_e'(op);

    always_comb begin
        s_d = s_q;
        if (s_q.active) begin
            // One byte per clock; new commands are not looked at.
            s_d.win = s_q.is_pop ? win_inc : win_dec;
            if (step_last) begin
                s_d.active = 1'b0;
                s_d.idx    = '0;
            end else begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end else begin
            s_d.idx = '0;
            case (op_e)
                OP_PUSH: begin s_d.active = 1'b1; s_d.is_pop = 1'b0; s_d.kind = FR_ONE;  end
                OP_POP:  begin s_d.active = 1'b1; s_d.is_pop = 1'b1; s_d.kind = FR_ONE;  end
                OP_CALL: begin s_d.active = 1'b1; s_d.is_pop = 1'b0; s_d.kind = FR_CALL; end
                OP_RET:  begin s_d.active = 1'b1; s_d.is_pop = 1'b1; s_d.kind = FR_CALL; end
                OP_INTR: begin s_d.active = 1'b1; s_d.is_pop = 1'b0; s_d.kind = FR_INTR; end
                OP_IRET: begin s_d.active = 1'b1; s_d.is_pop = 1'b1; s_d.kind = FR_INTR; end
                OP_RESET_SP: s_d.win = '1;
                OP_LOAD_LO:  s_d.win = sp_load_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.win    <= '1;
            s_q.active <= 1'b0;
            s_q.is_pop <= 1'b0;
            s_q.kind   <= FR_ONE;
            s_q.idx    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        sp       = addr_cur;
        busy     = s_q.active;
        mem_we   = s_q.active & ~s_q.is_pop;
        mem_re   = s_q.active &  s_q.is_pop;
        mem_addr = s_q.is_pop ? addr_inc : addr_cur;
        data_sel = s_q.active ? 3'(step_sel) : 3'(SEL_OPND);
    end
endmodule

// File: rtl/spu_chk.sv
module spu_chk #(
    parameter int SP_W   = 16,
    parameter int PAGE_W = 8,
    parameter int WIN_W  = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      op,
    input logic [SP_W-1:0] sp,
    input logic            busy,
    input logic            mem_we,
    input logic            mem_re,
    input logic [SP_W-1:0] mem_addr,
    input logic [2:0]      data_sel
);
    localparam logic [SP_W-1:0] TOP = SP_W'((1 << PAGE_W) - 1);

    a_r2_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (sp[SP_W-1:PAGE_W] == '0) && (&sp[PAGE_W-1:WIN_W]));

    a_r3_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp));

    a_r3_push_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp[WIN_W-1:0] == WIN_W'($past(sp[WIN_W-1:0]) - 1'b1)));

    a_r4_pop_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp == $past(mem_addr)));

    a_r12_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r12_busy_access: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (mem_we || mem_re));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op == 4'd0) |=> ($stable(sp) && !busy));

    a_r9_reset_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op == 4'd7) |=> (sp == TOP && !busy));

    a_r7_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (data_sel <= 3'd5));
endmodule

bind stack_ptr_unit spu_chk #(.SP_W(SP_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .sp       (sp),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .data_sel (data_sel)
);

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
    localparam int CLK_HALF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [5:0]  sp_load_val = 6'd0;
    logic [15:0] sp, mem_addr;
    logic        busy, mem_we, mem_re;
    logic [2:0]  data_sel;

    int compared = 0;
    int mismatched = 0;
    logic [5:0] mw;   // bench model of the writable bits

    always #CLK_HALF clk = ~clk;

    stack_ptr_unit dut (
        .clk(clk), .rst_n(rst_n), .op(op), .sp_load_val(sp_load_val),
        .sp(sp), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .data_sel(data_sel)
    );

    function automatic logic [15:0] full(logic [5:0] w);
        return {8'h00, 2'b11, w};
    endfunction

    function automatic int frame_len(logic [3:0] c);
        case (c)
            4'd1, 4'd2: return 1;
            4'd3, 4'd4: return 2;
            4'd5, 4'd6: return 5;
            default:    return 0;
        endcase
    endfunction

    function automatic logic [2:0] exp_sel(logic [3:0] c, int i);
        case (c)
            4'd3: return (i == 0) ? 3'd1 : 3'd2;
            4'd4: return (i == 0) ? 3'd2 : 3'd1;
            4'd5: return 3'(i + 1);
            4'd6: return 3'(5 - i);
            default: return 3'd0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Issue a command at a falling edge. The noise flag drives random commands while busy (R11).
    task automatic run(logic [3:0] c, logic [5:0] v, bit noise, string req);
        int n;
        bit pop;
        n   = frame_len(c);
        pop = (c == 4'd2) || (c == 4'd4) || (c == 4'd6);
        op = c;
        sp_load_val = v;
        @(posedge clk);
        @(negedge clk);
        op = noise ? 4'($urandom_range(1, 8)) : 4'd0;
        sp_load_val = 6'($urandom);
        for (int i = 0; i < n; i++) begin
            logic [15:0] ea;
            if (pop) begin
                mw = mw + 6'd1;
                ea = full(mw);
            end else begin
                ea = full(mw);
                mw = mw - 6'd1;
            end
            check(req, "busy", {31'd0, busy}, 32'd1);
            check(req, "mem_we", {31'd0, mem_we}, {31'd0, !pop});
            check(req, "mem_re", {31'd0, mem_re}, {31'd0, pop});
            check(req, "mem_addr", {16'd0, mem_addr}, {16'd0, ea});
            check(req, "data_sel", {29'd0, data_sel}, {29'd0, exp_sel(c, i)});
            if (noise) op = 4'($urandom_range(1, 8));
            @(posedge clk);
            @(negedge clk);
        end
        op = 4'd0;
        if (c == 4'd7) mw = 6'h3F;
        if (c == 4'd8) mw = v;
        check(req, "idle after", {31'd0, busy}, 32'd0);
        check(req, "no access", {30'd0, mem_we, mem_re}, 32'd0);
        check("R2", "sp", {16'd0, sp}, {16'd0, full(mw)});
    endtask

    initial begin
        #(2 * CLK_HALF * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        mw = 6'h3F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check("R1", "sp in reset", {16'd0, sp}, 32'h00FF);
        check("R1", "busy in reset", {31'd0, busy}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "sp after reset", {16'd0, sp}, 32'h00FF);
        check("R1", "strobes after reset", {30'd0, mem_we, mem_re}, 32'd0);

        // R12 idle hold
        repeat (3) @(negedge clk);
        check("R12", "idle sp", {16'd0, sp}, 32'h00FF);

        // R3, R4 single push then pop
        run(4'd1, 6'd0, 1'b0, "R3");
        check("R3", "sp after push", {16'd0, sp}, 32'h00FE);
        run(4'd2, 6'd0, 1'b0, "R4");
        check("R4", "sp after pop", {16'd0, sp}, 32'h00FF);

        // R5 wrap both ways
        run(4'd2, 6'd0, 1'b0, "R5");
        check("R5", "pop wraps to bottom", {16'd0, sp}, 32'h00C0);
        run(4'd1, 6'd0, 1'b0, "R5");
        check("R5", "push wraps to top", {16'd0, sp}, 32'h00FF);

        // R10 load low bits
        run(4'd8, 6'h15, 1'b0, "R10");
        check("R10", "load 15", {16'd0, sp}, 32'h00D5);
        run(4'd8, 6'h00, 1'b0, "R10");
        check("R10", "load 00", {16'd0, sp}, 32'h00C0);

        // R9 reset stack
        run(4'd7, 6'd0, 1'b0, "R9");
        check("R9", "reset stack", {16'd0, sp}, 32'h00FF);

        // R6 call / return
        run(4'd3, 6'd0, 1'b0, "R6");
        check("R6", "sp after call", {16'd0, sp}, 32'h00FD);
        run(4'd4, 6'd0, 1'b0, "R6");
        check("R6", "sp after return", {16'd0, sp}, 32'h00FF);

        // R7, R8 interrupt frame from top, then wrapping near bottom
        run(4'd5, 6'd0, 1'b0, "R7");
        check("R7", "sp after interrupt", {16'd0, sp}, 32'h00FA);
        run(4'd6, 6'd0, 1'b0, "R8");
        check("R8", "sp after iret", {16'd0, sp}, 32'h00FF);
        run(4'd8, 6'h02, 1'b0, "R10");
        run(4'd5, 6'd0, 1'b1, "R7");
        check("R5", "interrupt wraps", {16'd0, sp}, 32'h00FD);
        run(4'd6, 6'd0, 1'b1, "R8");
        check("R5", "iret wraps back", {16'd0, sp}, 32'h00C2);

        // R11 commands while busy are ignored
        run(4'd5, 6'd0, 1'b1, "R11");
        run(4'd3, 6'd0, 1'b1, "R11");

        // Random mix
        for (int k = 0; k < 600; k++) begin
            logic [3:0] c;
            c = 4'($urandom_range(0, 8));
            if (c == 4'd0) begin
                @(negedge clk);
                check("R12", "idle no op", {16'd0, sp}, {16'd0, full(mw)});
            end else begin
                run(c, 6'($urandom), 1'($urandom), "R11");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule